// File: doc/BRIEF.md
# SPI master transaction sequencer

This block is the control core on the master side of a serial peripheral interface controller. A one-cycle start command begins a transaction. The block asserts a programmable set of slave-select lines and waits a programmable setup gap. It then shifts characters out of an external transmit FIFO and into an external receive FIFO, one bit per serial clock period, and waits a programmable hold gap before it releases the select lines.

When a transaction ends, the block looks at the transmit FIFO. If the FIFO still holds data, the block waits an inactive gap and starts the next transaction without any further command. If the FIFO is empty, it halts and clears its running indication. Serial clock timing comes from an external half-period strobe. The block only turns that strobe into clock edges, so one sequencer can serve any divider.

Configuration inputs are expected to stay steady while a transaction is in flight. The block reports busy, a running bit that clears itself, and three sticky event flags.

Top module: `spi_txn_seq`

## Requirements
- R1: A high `start` in a clock cycle in which the block is idle begins a transaction. `running` rises together with `busy` on the following clock edge. `running` stays high across chained transactions and falls in the cycle in which the block halts. A `start` that arrives while a transaction chain is active has no effect.
- R2: At the end of each transaction, `tx_empty` is sampled. If it is low, a new transaction begins after the inactive gap. If it is high, the block returns to idle.
- R3: After select assertion, the block holds for `pre_dly` clock cycles, where the value 0 means 256. Only after that do serial clock edges begin, one edge on each later cycle in which `sclk_tick` is high.
- R4: After the last clock edge of the last character, the block holds select for `post_dly` cycles. Between two chained transactions it waits `gap_dly` cycles. For both, the value 0 means 256.
- R5: When `keep_sel` is 1, select stays asserted at the end of a transaction and through the following idle time. If the block is idle and `keep_sel` is 0 while select is still asserted, select is released on the next clock edge.
- R6: Line i of `sel_out` is active when select is asserted and `sel_mask[i]` is 1; otherwise it is inactive. The active level of line i is `sel_pol[i]`, where 1 means active high and 0 means active low. Any number of lines may be active at once.
- R7: `char_len` gives the bits per character: values 1 to 15 mean that many bits, and 0 means 16. The low `char_len` bits of each transmit word go out most significant bit first.
- R8: A transaction carries max(`tx_count`, `rx_count`) characters. `tx_pop` pulses when character k is loaded, for k < `tx_count`, provided the FIFO is not empty; otherwise that character is all zeros and nothing is popped. `rx_push` pulses for one cycle after each character k < `rx_count`. When both counts are zero, the setup gap is followed directly by the hold gap.
- R9: `busy` is high from the cycle after the start edge (or the edge that ends the inactive gap) until the edge that ends the hold gap.
- R10: Three sticky flags are kept. `done_flag` is set when each transaction ends. `ssa_flag` is set when select goes from released to asserted. `ssd_flag` is set when select goes from asserted to released. A 1 on `flag_clr` bit 0, 1 or 2 clears `done_flag`, `ssa_flag` or `ssd_flag` respectively, and a set in the same cycle wins over the clear.
- R11: `sclk` idles at `cpol`. When `cpha` is 0, data is sampled on the first edge of each bit and changes on the second. When `cpha` is 1, data changes on the first edge and is sampled on the second.
- R12: A received character is presented on `rx_data` right-justified, with all unused upper bits zero and the first received bit in the most significant used position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command to begin a transaction chain |
| keep_sel | input | 1 | Keep select asserted at transaction end |
| sel_mask | input | NSEL | Which select lines take part |
| sel_pol | input | NSEL | Active level of each select line (1 = high) |
| char_len | input | LENW | Bits per character, 0 = 16 |
| tx_count | input | CNTW | Characters to transmit per transaction |
| rx_count | input | CNTW | Characters to receive per transaction |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sample on second edge when 1 |
| pre_dly | input | DLYW | Setup gap in cycles, 0 = 256 |
| post_dly | input | DLYW | Hold gap in cycles, 0 = 256 |
| gap_dly | input | DLYW | Inactive gap between chained transactions, 0 = 256 |
| sclk_tick | input | 1 | Half-period strobe for the serial clock |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 2**LENW | Head word of the transmit FIFO |
| tx_pop | output | 1 | Take the head word of the transmit FIFO |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 2**LENW | Received character, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_out | output | NSEL | Slave-select lines |
| busy | output | 1 | Transaction in progress |
| running | output | 1 | Self-clearing start bit |
| flag_clr | input | 3 | Clear strobes for done, select-asserted and select-released flags |
| done_flag | output | 1 | Sticky transaction-done flag |
| ssa_flag | output | 1 | Sticky select-asserted flag |
| ssd_flag | output | 1 | Sticky select-released flag |

## Verification
The bench builds the block with its default parameters: four select lines, a 4-bit length field (characters up to 16 bits), 16-bit character counts and 8-bit gap counters. The 8-bit gap width keeps the case where 0 stands for 256 cycles short enough to run both for the setup gap and for the hold gap. The 4-bit length field makes both the 1-bit and the full 16-bit character reachable. All four clock modes are used. So are chains in which the FIFO runs dry in the middle of a transaction, a transaction with zero characters, and a kept select that is later released while the block is idle.

// File: rtl/spi_txn_seq.sv
module spi_txn_seq #(
  parameter int NSEL = 4,
  parameter int LENW = 4,
  parameter int CNTW = 16,
  parameter int DLYW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 keep_sel,
  input  logic [NSEL-1:0]      sel_mask,
  input  logic [NSEL-1:0]      sel_pol,
  input  logic [LENW-1:0]      char_len,
  input  logic [CNTW-1:0]      tx_count,
  input  logic [CNTW-1:0]      rx_count,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic [DLYW-1:0]      pre_dly,
  input  logic [DLYW-1:0]      post_dly,
  input  logic [DLYW-1:0]      gap_dly,
  input  logic                 sclk_tick,
  input  logic                 tx_empty,
  input  logic [(1<<LENW)-1:0] tx_data,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [(1<<LENW)-1:0] rx_data,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NSEL-1:0]      sel_out,
  output logic                 busy,
  output logic                 running,
  input  logic [2:0]           flag_clr,
  output logic                 done_flag,
  output logic                 ssa_flag,
  output logic                 ssd_flag
);
  localparam int CHW = 1 << LENW;
  localparam int HW = LENW + 1;
  localparam logic [LENW:0] FULL = (LENW+1)'(CHW);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SHIFT, S_POST, S_GAP} state_t;
  state_t st;

  logic [DLYW-1:0] dcnt;
  logic [HW-1:0]   half;
  logic [CNTW-1:0] ci;
  logic [CHW-1:0]  txsr, rxsr;
  logic            ss_act, lvl;

  wire [LENW:0]   nbits     = (char_len == '0) ? FULL : {1'b0, char_len};
  wire [CNTW-1:0] nchar     = (tx_count > rx_count) ? tx_count : rx_count;
  wire [HW:0]     twob      = {nbits, 1'b0};
  wire            dly_end   = (dcnt == '0);
  wire            last_half = ({1'b0, half} == twob - 1'b1);
  wire            sample    = sclk_tick & (half[0] == cpha);
  wire            char_done = (st == S_SHIFT) & sclk_tick & last_half;
  wire [CNTW:0]   ci_n      = {1'b0, ci} + 1'b1;
  wire            more      = ci_n < {1'b0, nchar};
  wire            pre_go    = (st == S_PRE) & dly_end & (nchar != '0);
  wire            load      = pre_go | (char_done & more);
  wire [CNTW-1:0] next_idx  = pre_go ? '0 : ci_n[CNTW-1:0];
  wire            take      = load & (next_idx < tx_count) & ~tx_empty;
  wire [CHW-1:0]  rx_next   = sample ? {rxsr[CHW-2:0], miso} : rxsr;
  wire [LENW:0]   oidx      = (cpha && half != '0) ? (half - 1'b1) >> 1 : half >> 1;
  wire [CHW-1:0]  tx_view   = txsr << oidx;
  wire            post_end  = (st == S_POST) & dly_end;
  wire            ss_on     = ~ss_act & (((st == S_IDLE) & start) | ((st == S_GAP) & dly_end));
  wire            ss_off    = ss_act & ~keep_sel & (post_end | ((st == S_IDLE) & ~start));

  assign tx_pop  = take;
  assign mosi    = (st == S_SHIFT) & tx_view[CHW-1];
  assign sclk    = cpol ^ lvl;
  assign sel_out = ~(sel_pol ^ ({NSEL{ss_act}} & sel_mask));
  assign busy    = (st == S_PRE) | (st == S_SHIFT) | (st == S_POST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; half <= '0; ci <= '0;
      txsr <= '0; rxsr <= '0; ss_act <= 1'b0; lvl <= 1'b0;
      running <= 1'b0; rx_push <= 1'b0; rx_data <= '0;
      done_flag <= 1'b0; ssa_flag <= 1'b0; ssd_flag <= 1'b0;
    end else begin
      rx_push   <= 1'b0;
      ss_act    <= (ss_act | ss_on) & ~ss_off;
      done_flag <= (done_flag & ~flag_clr[0]) | post_end;
      ssa_flag  <= (ssa_flag & ~flag_clr[1]) | ss_on;
      ssd_flag  <= (ssd_flag & ~flag_clr[2]) | ss_off;
      case (st)
        S_IDLE: if (start) begin
          st <= S_PRE; dcnt <= pre_dly - 1'b1; running <= 1'b1;
        end
        S_PRE: if (dly_end) begin
          if (nchar != '0) st <= S_SHIFT;
          else begin st <= S_POST; dcnt <= post_dly - 1'b1; end
        end else dcnt <= dcnt - 1'b1;
        S_SHIFT: if (sclk_tick) begin
          lvl  <= ~lvl;
          half <= half + 1'b1;
          rxsr <= rx_next;
          if (last_half) begin
            if (ci < rx_count) begin rx_push <= 1'b1; rx_data <= rx_next; end
            if (!more) begin st <= S_POST; dcnt <= post_dly - 1'b1; end
          end
        end
        S_POST: if (dly_end) begin
          if (!tx_empty) begin st <= S_GAP; dcnt <= gap_dly - 1'b1; end
          else begin st <= S_IDLE; running <= 1'b0; end
        end else dcnt <= dcnt - 1'b1;
        S_GAP: if (dly_end) begin
          st <= S_PRE; dcnt <= pre_dly - 1'b1;
        end else dcnt <= dcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (load) begin
        txsr <= take ? tx_data << (FULL - nbits) : '0;
        rxsr <= '0;
        half <= '0;
        ci   <= next_idx;
      end
    end
  end

  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
  assert_done_on_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  assert_run_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> !busy);
  assert_push_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> busy);
  assert_pop_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> busy);
  assert_ssa_starts_txn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssa_flag) |-> busy);
endmodule

// File: tb/tb_spi_txn_seq.sv
`timescale 1ns/1ps
module tb_spi_txn_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, keep_sel = 0, cpol = 0, cpha = 0, miso = 0, sclk_tick = 0;
  logic [3:0] sel_mask = 4'b0101, sel_pol = 4'b0001, char_len = 4'd8;
  logic [15:0] tx_count = 16'd2, rx_count = 16'd2;
  logic [7:0] pre_dly = 8'd2, post_dly = 8'd3, gap_dly = 8'd4;
  logic [2:0] flag_clr = 3'b000;
  logic tx_empty = 1'b1;
  logic [15:0] tx_data = 16'h0;
  logic tx_pop, rx_push, sclk, mosi, busy, running, done_flag, ssa_flag, ssd_flag;
  logic [15:0] rx_data;
  logic [3:0] sel_out;

  always #4 clk = ~clk;

  spi_txn_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .keep_sel(keep_sel),
    .sel_mask(sel_mask), .sel_pol(sel_pol), .char_len(char_len),
    .tx_count(tx_count), .rx_count(rx_count), .cpol(cpol), .cpha(cpha),
    .pre_dly(pre_dly), .post_dly(post_dly), .gap_dly(gap_dly),
    .sclk_tick(sclk_tick), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk),
    .mosi(mosi), .miso(miso), .sel_out(sel_out), .busy(busy),
    .running(running), .flag_clr(flag_clr), .done_flag(done_flag),
    .ssa_flag(ssa_flag), .ssd_flag(ssd_flag)
  );

  int n_chk = 0, n_fail = 0, busy_rises = 0;
  bit model_on = 0, ended = 0;
  logic pop_seen = 0, busy_prev = 0;
  logic [15:0] txq[$];
  logic [15:0] mq[$];
  logic [15:0] lfsr = 16'hACE1;
  int tcnt = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    tcnt = (tcnt == 2) ? 0 : tcnt + 1;
    sclk_tick = (tcnt == 0);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  always @(posedge clk) begin
    if (pop_seen && txq.size() > 0) void'(txq.pop_front());
    tx_data  <= (txq.size() > 0) ? txq[0] : 16'h0;
    tx_empty <= (txq.size() == 0);
  end

  task automatic push_word(input logic [15:0] v);
    txq.push_back(v); mq.push_back(v);
    tx_data = txq[0]; tx_empty = 1'b0;
  endtask

  // behavioural reference
  logic e_busy = 0, e_run = 0, e_ss = 0, e_lvl = 0, e_mosi = 0, e_push = 0;
  logic [15:0] e_rxd = 0;
  logic [2:0] e_fl = 0;
  logic s_tick, s_start, s_miso, s_pop;
  logic [2:0] s_clr;

  task automatic edge_in();
    @(posedge clk);
    s_tick = sclk_tick; s_start = start; s_miso = miso; s_clr = flag_clr; s_pop = pop_seen;
  endtask

  task automatic commit(input logic [2:0] setm, input logic xpop, input logic push);
    e_fl = (e_fl & ~s_clr) | setm;
    chk(s_pop === xpop, "R8", "tx_pop", s_pop, xpop);
    e_push = push;
  endtask

  function automatic int dly(input logic [7:0] v);
    return (v == 0) ? 256 : int'(v);
  endfunction

  task automatic run_txn();
    logic [2:0] sm;
    logic [15:0] ch, rxv;
    int n, b, tx, rx, h, idx;
    logic push_p, take;
    e_run = 1;
    forever begin
      sm = e_ss ? 3'b000 : 3'b010;
      e_ss = 1; e_busy = 1;
      commit(sm, 0, 0);
      n = (tx_count > rx_count) ? int'(tx_count) : int'(rx_count);
      b = (char_len == 0) ? 16 : int'(char_len);
      tx = int'(tx_count); rx = int'(rx_count);
      for (int k = 1; k < dly(pre_dly); k++) begin edge_in(); commit(0, 0, 0); end
      edge_in();
      push_p = 0;
      for (int c = 0; c < n; c++) begin
        take = (c < tx) && (mq.size() > 0);
        ch = 16'h0;
        if (take) ch = mq.pop_front();
        rxv = 16'h0; h = 0;
        e_mosi = ch[b-1];
        commit(0, take, push_p);
        while (h < 2*b) begin
          edge_in();
          if (s_tick) begin
            if (((h % 2) == 0) == (cpha == 0)) rxv = {rxv[14:0], s_miso};
            e_lvl = ~e_lvl; h++;
            if (h < 2*b) begin
              idx = (cpha && h != 0) ? (h-1)/2 : h/2;
              e_mosi = ch[b-1-idx];
              commit(0, 0, 0);
            end
          end else commit(0, 0, 0);
        end
        push_p = (c < rx);
        if (push_p) e_rxd = rxv;
      end
      e_mosi = 0;
      commit(0, 0, push_p);
      for (int k = 1; k < dly(post_dly); k++) begin edge_in(); commit(0, 0, 0); end
      edge_in();
      sm = 3'b001; e_busy = 0;
      if (!keep_sel) begin e_ss = 0; sm = sm | 3'b100; end
      if (mq.size() == 0) begin e_run = 0; commit(sm, 0, 0); return; end
      commit(sm, 0, 0);
      for (int k = 1; k < dly(gap_dly); k++) begin edge_in(); commit(0, 0, 0); end
      edge_in();
    end
  endtask

  initial begin : ref_model
    @(posedge rst_n);
    forever begin
      edge_in();
      if (s_start) run_txn();
      else if (e_ss && !keep_sel) begin e_ss = 0; commit(3'b100, 0, 0); end
      else commit(0, 0, 0);
    end
  end

  always @(negedge clk) begin
    #2;
    pop_seen = tx_pop;
    if (model_on) begin
      logic [3:0] xs;
      xs = ~(sel_pol ^ ({4{e_ss}} & sel_mask));
      chk(busy === e_busy, "R4/R9", "busy", busy, e_busy);
      chk(running === e_run, "R1", "running", running, e_run);
      chk(sel_out === xs, "R5/R6", "sel_out", sel_out, xs);
      chk(sclk === (cpol ^ e_lvl), "R3/R11", "sclk", sclk, cpol ^ e_lvl);
      chk(mosi === e_mosi, "R7", "mosi", mosi, e_mosi);
      chk({ssd_flag, ssa_flag, done_flag} === e_fl, "R10", "flags",
          {ssd_flag, ssa_flag, done_flag}, e_fl);
      chk(rx_push === e_push, "R8", "rx_push", rx_push, e_push);
      if (e_push) chk(rx_data === e_rxd, "R12", "rx_data", rx_data, e_rxd);
      if (busy && !busy_prev) busy_rises++;
      busy_prev = busy;
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_halt();
    while (running || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : stimulus
    repeat (3) @(negedge clk);
    #2;
    chk(busy === 0 && running === 0, "R1", "reset busy/running", {busy, running}, 0);
    chk({ssd_flag, ssa_flag, done_flag} === 3'b000, "R10", "reset flags",
        {ssd_flag, ssa_flag, done_flag}, 0);
    chk(sel_out === ~sel_pol, "R6", "reset sel_out", sel_out, ~sel_pol);
    chk(tx_pop === 0 && rx_push === 0, "R8", "reset pop/push", {tx_pop, rx_push}, 0);
    @(negedge clk); rst_n = 1; model_on = 1;

    // mode 0, 8-bit, two chained transactions
    push_word(16'h00A5); push_word(16'h003C); push_word(16'h0081); push_word(16'h007E);
    busy_rises = 0;
    pulse_start();
    wait_halt();
    chk(busy_rises == 2, "R2", "transactions in chain", busy_rises, 2);
    chk(txq.size() == 0, "R2", "fifo drained", txq.size(), 0);

    // mode 3, 16-bit, 256-cycle setup, kept select
    @(negedge clk);
    flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
    cpol = 1; cpha = 1; char_len = 4'd0; tx_count = 16'd1; rx_count = 16'd3;
    pre_dly = 8'd0; post_dly = 8'd1; keep_sel = 1; sel_mask = 4'b1010; sel_pol = 4'b1000;
    push_word(16'hC3A1);
    pulse_start();
    wait_halt();
    chk(sel_out === 4'b1101, "R5", "select kept after halt", sel_out, 4'b1101);
    keep_sel = 0;
    repeat (2) @(negedge clk);
    chk(sel_out === 4'b0111, "R5", "select released when idle", sel_out, 4'b0111);
    chk(ssd_flag === 1, "R10", "release flag", ssd_flag, 1);

    // mode 1, 1-bit characters, FIFO runs dry in second transaction, 256-cycle hold
    cpol = 0; cpha = 1; char_len = 4'd1; tx_count = 16'd3; rx_count = 16'd0;
    pre_dly = 8'd1; post_dly = 8'd0; gap_dly = 8'd1; sel_mask = 4'b1111; sel_pol = 4'b0000;
    push_word(16'h0001); push_word(16'h0000); push_word(16'h0001); push_word(16'h0001);
    busy_rises = 0;
    pulse_start();
    wait_halt();
    chk(busy_rises == 2, "R2", "chain after partial drain", busy_rises, 2);

    // mode 2, 5-bit, zero characters, start during busy ignored
    cpol = 1; cpha = 0; char_len = 4'd5; tx_count = 16'd0; rx_count = 16'd0;
    pre_dly = 8'd6; post_dly = 8'd2; sel_mask = 4'b0001; sel_pol = 4'b0001;
    busy_rises = 0;
    pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wait_halt();
    chk(busy_rises == 1, "R1", "start during busy ignored", busy_rises, 1);
    chk(done_flag === 1, "R10", "done set", done_flag, 1);

    // mode 0, 12-bit, receive only with empty FIFO
    cpol = 0; cpha = 0; char_len = 4'd12; tx_count = 16'd0; rx_count = 16'd2;
    pre_dly = 8'd3; post_dly = 8'd3;
    pulse_start();
    wait_halt();
    finish_up();
  end
endmodule